// File: doc/BRIEF.md
# Ping-Pong Card Data Buffer

This block is the data store between a host-side 32-bit data register and a card-side word stream in an SD/MMC-style host controller. One direction input picks the path. In card-to-host transfers the card stream fills the buffer and the host drains it by reading the data register. In host-to-card transfers the host fills the buffer by writing the data register and the card stream drains it. Whichever side fills goes through a one-word post-write stage. Whichever side drains is served from a one-word prefetch stage, which is loaded ahead of time from the buffer memory.

The block length is an 11-bit byte count. One block is ceil(blkLen/4) 32-bit words. For blocks of up to 512 bytes, the memory is split into two portions of one block each, and they are used alternately. One side can then fill a block while the other side empties the previous one. For longer blocks, one portion covers the whole block, so only one side moves data at any time. Host accesses are gated by a read-enable and a write-enable status. An access made while its enable is low is refused and latches a sticky bad-access flag.

Top module: `pingpong_card_buffer`

## Requirements
- R1: After reset, with xferEn low, rdEnable, wrEnable, cardInReady, cardOutValid and badAccess are all 0.
- R2: One block is ceil(blkLen/4) words. In card-to-host mode, rdEnable stays 0 until that many card words have been accepted into a portion.
- R3: While rdEnable is 1, hostRdata holds the oldest unread word. It stays stable until a host read. Reads within one block may follow on consecutive cycles, and words come out in card order.
- R4: A host read while rdEnable is 0 sets badAccess and consumes no data.
- R5: A host write while wrEnable is 0 sets badAccess, and its data never reaches the card stream.
- R6: badAccess stays 1 until a cycle with badClr high and no new bad access. A bad access in the same cycle as badClr leaves it 1.
- R7: With blkLen at most 512 (for example 512 itself), two portions are used. After one full unread block, the filling side can still fill a second one. After two unread blocks, the filling side is held off until the first block is drained.
- R8: With blkLen above 512, a single portion is used. After one full block, cardInReady stays 0 until the host has read the whole block. A host read during the card fill is a bad access.
- R9: In host-to-card mode, wrEnable is 1 while an empty portion exists. Host words appear on cardOutData in write order, and cardOutValid/cardOutReady pace them.
- R10: rdEnable can be 1 only when cardToHost=1, and wrEnable only when cardToHost=0. A host write in card-to-host mode, or a host read in host-to-card mode, is a bad access.
- R11: Dropping xferEn for one cycle discards all buffered blocks. Afterwards rdEnable is 0 and, in card-to-host mode, cardInReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| xferEn | input | 1 | Transfer active; low clears buffer state |
| cardToHost | input | 1 | 1: card fills, host reads; 0: host writes, card drains |
| blkLen | input | 11 | Block length in bytes (nonzero, stable while xferEn) |
| hostWr | input | 1 | Host write strobe of the data register |
| hostWdata | input | 32 | Host write data |
| hostRd | input | 1 | Host read strobe of the data register |
| hostRdata | output | 32 | Host read data from the prefetch stage |
| rdEnable | output | 1 | Buffer read enable status |
| wrEnable | output | 1 | Buffer write enable status |
| badAccess | output | 1 | Sticky bad-access flag |
| badClr | input | 1 | Write-one-to-clear pulse for badAccess |
| cardInValid | input | 1 | Card-side word available (card-to-host) |
| cardInData | input | 32 | Card-side input word |
| cardInReady | output | 1 | Buffer accepts a card word |
| cardOutValid | output | 1 | Buffer word available to card (host-to-card) |
| cardOutData | output | 32 | Word to card from the prefetch stage |
| cardOutReady | input | 1 | Card consumes the offered word |

## Verification
Four properties are checked on every cycle. A refused host access always leads to badAccess on the next cycle. badAccess never falls without a clear. The two enables are never high together. In single-portion mode, filling and draining never happen in the same cycle. A further property holds hostRdata stable while rdEnable is high and no read is made. Only the bench scenarios can show the rest: word counts per block, the point at which the filling side is held off in each mode, data order across the portion swap, and data refused by a bad write never reaching the card.

// File: rtl/ppbuf_pkg.sv
package ppbuf_pkg;
  typedef struct packed {
    logic capture;   // fill word accepted this cycle: load post-write stage
    logic fromCard;  // fill source is the card stream
  } ppbuf_strobe_t;
endpackage

// File: rtl/ppbuf_datapath.sv
module ppbuf_datapath
  import ppbuf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 1024,
  localparam int ADDR_W   = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ppbuf_strobe_t     stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] cardInData,
  output logic              pwValid,
  output logic [ADDR_W-1:0] pwAddr,
  output logic [DATA_W-1:0] pfWord
);
  logic [DATA_W-1:0] mem [MEM_WORDS];
  logic [DATA_W-1:0] pwData;

  // post-write stage: one word held for a cycle before it lands in memory
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwValid <= 1'b0;
    else       pwValid <= stb.capture;
  end

  always_ff @(posedge clk) begin
    if (stb.capture) begin
      pwData <= stb.fromCard ? cardInData : hostWdata;
      pwAddr <= wrAddr;
    end
  end

  // memory write from post-write, prefetch load from the head address
  always_ff @(posedge clk) begin
    if (pwValid) mem[pwAddr] <= pwData;
    pfWord <= mem[rdAddr];
  end
endmodule

// File: rtl/ppbuf_ctrl.sv
module ppbuf_ctrl
  import ppbuf_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int BLEN_W    = 11,
  parameter int DBL_LIMIT = 512,
  localparam int CNT_W    = BLEN_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xferEn,
  input  logic              cardToHost,
  input  logic [BLEN_W-1:0] blkLen,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic              badClr,
  input  logic              cardInValid,
  input  logic              cardOutReady,
  input  logic              pwValid,
  input  logic [ADDR_W-1:0] pwAddr,
  output ppbuf_strobe_t     stb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdEnable,
  output logic              wrEnable,
  output logic              cardInReady,
  output logic              cardOutValid,
  output logic              badAccess
);
  logic [1:0]       full;
  logic             fillSel, drainSel, pfValid;
  logic [CNT_W-1:0] fillCnt, drainCnt, drainNext, blkW, fillBase, drainBase;
  logic [BLEN_W:0]  lenSum;
  logic             dbl, fillAcc, drainAcc, fillLast, drainLast, headHazard;
  logic             badRd, badWr;

  assign lenSum = {1'b0, blkLen} + (BLEN_W+1)'(3);
  assign blkW   = lenSum[BLEN_W:2];
  assign dbl    = blkLen <= BLEN_W'(DBL_LIMIT);

  assign wrEnable     = xferEn && !cardToHost && !full[fillSel];
  assign cardInReady  = xferEn &&  cardToHost && !full[fillSel];
  assign rdEnable     =  cardToHost && pfValid;
  assign cardOutValid = !cardToHost && pfValid;

  assign fillAcc  = cardToHost ? (cardInValid && cardInReady) : (hostWr && wrEnable);
  assign drainAcc = cardToHost ? (hostRd && rdEnable) : (cardOutReady && cardOutValid);
  assign fillLast  = fillCnt  == blkW - CNT_W'(1);
  assign drainLast = drainCnt == blkW - CNT_W'(1);

  assign fillBase  = (dbl && fillSel)  ? blkW : '0;
  assign drainBase = (dbl && drainSel) ? blkW : '0;
  assign drainNext = (drainAcc && !drainLast) ? drainCnt + CNT_W'(1) : drainCnt;
  assign wrAddr = ADDR_W'(fillBase)  + ADDR_W'(fillCnt);
  assign rdAddr = ADDR_W'(drainBase) + ADDR_W'(drainNext);
  assign headHazard = pwValid && (pwAddr == rdAddr);

  assign stb.capture  = fillAcc;
  assign stb.fromCard = cardToHost;

  assign badRd = hostRd && !rdEnable;
  assign badWr = hostWr && !wrEnable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      full <= '0; fillSel <= 1'b0; drainSel <= 1'b0;
      fillCnt <= '0; drainCnt <= '0; pfValid <= 1'b0; badAccess <= 1'b0;
    end else begin
      if (!xferEn) begin
        full <= '0; fillSel <= 1'b0; drainSel <= 1'b0;
        fillCnt <= '0; drainCnt <= '0; pfValid <= 1'b0;
      end else begin
        if (fillAcc) begin
          if (fillLast) begin
            full[fillSel] <= 1'b1;
            fillCnt <= '0;
            if (dbl) fillSel <= ~fillSel;
          end else fillCnt <= fillCnt + CNT_W'(1);
        end
        if (drainAcc) begin
          if (drainLast) begin
            full[drainSel] <= 1'b0;
            drainCnt <= '0;
            if (dbl) drainSel <= ~drainSel;
          end else drainCnt <= drainCnt + CNT_W'(1);
        end
        if (pfValid) pfValid <= !(drainAcc && drainLast);
        else         pfValid <= full[drainSel] && !headHazard;
      end
      if (badRd || badWr) badAccess <= 1'b1;
      else if (badClr)    badAccess <= 1'b0;
    end
  end

  p_bad_on_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    hostRd && !rdEnable |=> badAccess);
  p_bad_on_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    hostWr && !wrEnable |=> badAccess);
  p_bad_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    badAccess && !badClr |=> badAccess);
  p_enables_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEnable && wrEnable));
  p_single_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    !dbl |-> !(fillAcc && drainAcc));
endmodule

// File: rtl/pingpong_card_buffer.sv
module pingpong_card_buffer
  import ppbuf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 1024,
  parameter int BLEN_W    = 11,
  parameter int DBL_LIMIT = 512,
  localparam int ADDR_W   = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xferEn,
  input  logic              cardToHost,
  input  logic [BLEN_W-1:0] blkLen,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              hostRd,
  output logic [DATA_W-1:0] hostRdata,
  output logic              rdEnable,
  output logic              wrEnable,
  output logic              badAccess,
  input  logic              badClr,
  input  logic              cardInValid,
  input  logic [DATA_W-1:0] cardInData,
  output logic              cardInReady,
  output logic              cardOutValid,
  output logic [DATA_W-1:0] cardOutData,
  input  logic              cardOutReady
);
  ppbuf_strobe_t     stb;
  logic [ADDR_W-1:0] wrAddr, rdAddr, pwAddr;
  logic              pwValid;
  logic [DATA_W-1:0] pfWord;

  ppbuf_ctrl #(.ADDR_W(ADDR_W), .BLEN_W(BLEN_W), .DBL_LIMIT(DBL_LIMIT)) ctrl_i (
    .clk, .rstN, .xferEn, .cardToHost, .blkLen, .hostRd, .hostWr, .badClr,
    .cardInValid, .cardOutReady, .pwValid, .pwAddr, .stb, .wrAddr, .rdAddr,
    .rdEnable, .wrEnable, .cardInReady, .cardOutValid, .badAccess);

  ppbuf_datapath #(.DATA_W(DATA_W), .MEM_WORDS(MEM_WORDS)) dp_i (
    .clk, .rstN, .stb, .wrAddr, .rdAddr, .hostWdata, .cardInData,
    .pwValid, .pwAddr, .pfWord);

  assign hostRdata   = pfWord;
  assign cardOutData = pfWord;

  p_prefetch_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdEnable && !hostRd |=> $stable(hostRdata));
endmodule

// File: tb/pingpong_card_buffer_tb.sv
module pingpong_card_buffer_tb_top;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rstN = 1'b0, xferEn = 1'b0, cardToHost = 1'b1;
  logic [10:0] blkLen = 11'd4;
  logic hostWr = 0, hostRd = 0, badClr = 0, cardInValid = 0, cardOutReady = 0;
  logic [31:0] hostWdata = '0, cardInData = '0;
  logic [31:0] hostRdata, cardOutData;
  logic rdEnable, wrEnable, badAccess, cardInReady, cardOutValid;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pingpong_card_buffer dut_i (
    .clk, .rstN, .xferEn, .cardToHost, .blkLen, .hostWr, .hostWdata, .hostRd,
    .hostRdata, .rdEnable, .wrEnable, .badAccess, .badClr, .cardInValid,
    .cardInData, .cardInReady, .cardOutValid, .cardOutData, .cardOutReady);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic cardPush(input logic [31:0] d);
    cardInData = d; cardInValid = 1'b1; #1;
    while (!cardInReady) begin @(negedge clk); #1; end
    @(negedge clk); cardInValid = 1'b0;
  endtask

  task automatic hostRead(input string req, input logic [31:0] exp);
    #1;
    while (!rdEnable) begin @(negedge clk); #1; end
    chk(req, hostRdata, exp);
    hostRd = 1'b1; @(negedge clk); hostRd = 1'b0;
  endtask

  task automatic hostWrite(input logic [31:0] d);
    #1;
    while (!wrEnable) begin @(negedge clk); #1; end
    hostWdata = d; hostWr = 1'b1; @(negedge clk); hostWr = 1'b0;
  endtask

  task automatic cardPop(input string req, input logic [31:0] exp);
    #1;
    while (!cardOutValid) begin @(negedge clk); #1; end
    chk(req, cardOutData, exp);
    cardOutReady = 1'b1; @(negedge clk); cardOutReady = 1'b0;
  endtask

  task automatic restart(input logic dir, input logic [10:0] len);
    xferEn = 1'b0; cardToHost = dir; blkLen = len;
    @(negedge clk); xferEn = 1'b1;
  endtask

  task automatic clearBad();
    badClr = 1'b1; @(negedge clk); badClr = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 rdEnable", rdEnable, 0); chk("R1 wrEnable", wrEnable, 0);
    chk("R1 cardInReady", cardInReady, 0); chk("R1 cardOutValid", cardOutValid, 0);
    chk("R1 badAccess", badAccess, 0);
    @(negedge clk);
  endtask

  task automatic t_c2h_double();
    restart(1'b1, 11'd10);  // 3 words per block
    cardPush(32'hA0); cardPush(32'hA1);
    repeat (3) @(negedge clk);
    #1 chk("R2 no rdEnable before ceil(10/4) words", rdEnable, 0);
    @(negedge clk);
    cardPush(32'hA2); cardPush(32'hB0); cardPush(32'hB1); cardPush(32'hB2);
    #1 chk("R7 filler held after two blocks", cardInReady, 0);
    @(negedge clk);
    hostRead("R3 first word", 32'hA0);
    #1 chk("R3 rdEnable stays within block", rdEnable, 1);
    hostRead("R3 order", 32'hA1); hostRead("R3 order", 32'hA2);
    #1 chk("R7 portion freed after drain", cardInReady, 1);
    @(negedge clk);
    hostRead("R7 second portion", 32'hB0); hostRead("R7 second portion", 32'hB1);
    hostRead("R7 second portion", 32'hB2);
    #1 chk("R3 rdEnable low when empty", rdEnable, 0);
    @(negedge clk);
  endtask

  task automatic t_bad_access();
    restart(1'b1, 11'd4);   // 1 word per block
    hostRd = 1'b1; @(negedge clk); hostRd = 1'b0;
    #1 chk("R4 read while disabled flags", badAccess, 1);
    repeat (5) @(negedge clk);
    #1 chk("R6 sticky", badAccess, 1);
    @(negedge clk);
    cardPush(32'hC0);
    hostRead("R4 refused read consumed nothing", 32'hC0);
    clearBad();
    #1 chk("R6 cleared", badAccess, 0);
    @(negedge clk);
    hostRd = 1'b1; badClr = 1'b1; @(negedge clk); hostRd = 1'b0; badClr = 1'b0;
    #1 chk("R6 set wins over clear", badAccess, 1);
    @(negedge clk); clearBad();
    hostWdata = 32'h1234; hostWr = 1'b1; @(negedge clk); hostWr = 1'b0;
    #1 chk("R10 write in card-to-host is bad", badAccess, 1);
    chk("R10 wrEnable low in card-to-host", wrEnable, 0);
    @(negedge clk); clearBad();
  endtask

  task automatic t_h2c();
    restart(1'b0, 11'd8);   // 2 words per block
    hostWrite(32'hD0); hostWrite(32'hD1); hostWrite(32'hD2); hostWrite(32'hD3);
    #1 chk("R9 wrEnable low after two blocks", wrEnable, 0);
    chk("R10 rdEnable low in host-to-card", rdEnable, 0);
    @(negedge clk);
    hostWdata = 32'hDEAD; hostWr = 1'b1; @(negedge clk); hostWr = 1'b0;
    #1 chk("R5 write while disabled flags", badAccess, 1);
    @(negedge clk); clearBad();
    cardPop("R9 order", 32'hD0); cardPop("R9 order", 32'hD1);
    cardPop("R9 order", 32'hD2); cardPop("R9 order", 32'hD3);
    repeat (3) @(negedge clk);
    #1 chk("R5 refused data never sent", cardOutValid, 0);
    chk("R9 wrEnable back", wrEnable, 1);
    @(negedge clk);
  endtask

  task automatic t_modes();
    restart(1'b1, 11'd512); // 128 words, still double
    for (int i = 0; i < 128; i++) cardPush(32'h4000_0000 + i);
    #1 chk("R7 boundary 512 keeps second portion", cardInReady, 1);
    @(negedge clk);
    restart(1'b1, 11'd516); // 129 words, single portion
    for (int i = 0; i < 10; i++) cardPush(32'h5000_0000 + i);
    hostRd = 1'b1; @(negedge clk); hostRd = 1'b0;
    #1 chk("R8 read during card fill is bad", badAccess, 1);
    @(negedge clk); clearBad();
    for (int i = 10; i < 129; i++) cardPush(32'h5000_0000 + i);
    #1 chk("R8 card held after one block", cardInReady, 0);
    @(negedge clk);
    for (int i = 0; i < 64; i++) hostRead("R8 data", 32'h5000_0000 + i);
    #1 chk("R8 card held during host drain", cardInReady, 0);
    @(negedge clk);
    for (int i = 64; i < 129; i++) hostRead("R8 data", 32'h5000_0000 + i);
    #1 chk("R8 card released after drain", cardInReady, 1);
    chk("R8 no stray badAccess", badAccess, 0);
    @(negedge clk);
  endtask

  task automatic t_xfer_clear();
    restart(1'b1, 11'd4);
    cardPush(32'hE0); cardPush(32'hE1);
    #1 chk("R11 precondition full", cardInReady, 0);
    @(negedge clk);
    restart(1'b1, 11'd4);
    #1 chk("R11 rdEnable cleared", rdEnable, 0);
    chk("R11 cardInReady restored", cardInReady, 1);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_c2h_double();
    t_bad_access();
    t_h2c();
    t_modes();
    t_xfer_clear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule